// File: doc/BRIEF.md
# BCD clock calendar counter

This block holds a time-of-day and calendar value as packed BCD fields: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. It advances on a slow tick input. After a parameterised number of ticks (`TICK_DIV`, default 1) it adds one hundredth of a second. A carry then moves up through the larger fields, one field per clock cycle, under a small sequencing state machine.

A serial access controller that is outside this block uses two parallel ports. It writes all eight 8-bit registers in one cycle through `load_data_i`/`load_i`, and it reads the live register image on `rd_data_o`. Register `k` sits in bits `[8k+7:8k]`. The hours register carries its own 12/24-hour mode bit and changes format in place, with no conversion. The day-of-week register also holds a bit that stops the clock and a reset-mask bit, which is copied to `reset_mask_o` for the controller.

The sequencer has seven states. `ST_IDLE` waits for a step and adds one hundredth. It moves to `ST_SEC` when hundredths pass 99, and otherwise stays. `ST_SEC` moves to `ST_MIN` on 59→00. `ST_MIN` moves to `ST_HOUR` on 59→00. `ST_HOUR` moves to `ST_DATE` when the day rolls over. `ST_DATE` also advances the day of week, and moves to `ST_MONTH` when the last date of the month rolls over. `ST_MONTH` moves to `ST_YEAR` on 12→01. `ST_YEAR` always returns to `ST_IDLE`. A state returns to `ST_IDLE` when its field does not carry, and a load forces `ST_IDLE` from any state.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the image is hundredths 00, seconds 00, minutes 00, hours 0x00 (24-hour), day 0x01 (running, mask clear), date 01, month 01, year 00.
- R2: A load replaces all eight registers in one cycle. The following bit positions always read 0: seconds bit 7, minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7 and 6, month bits 7 to 5.
- R3: Hundredths advance by one BCD count on every `TICK_DIV`-th tick while running, and wrap from 99 to 00. A load clears the partial tick count.
- R4: A hundredths wrap carries into seconds. Seconds 59→00 carries into minutes, and minutes 59→00 carries into hours.
- R5: With hours bit 7 = 0 (24-hour mode), hours bits 5:0 count 00 to 23 and wrap to 00, which advances the date.
- R6: With hours bit 7 = 1 (12-hour mode), bits 4:0 count 12, 01 … 11. Bit 5 (1 = PM) toggles on 11→12. Only 11 PM→12 AM advances the date.
- R7: Day of week (day bits 2:0) counts 1 to 7 and wraps to 1 on each date advance.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in month 02 after 29 when the binary year is a multiple of 4 (including 00) or after 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: While day bit 5 is 1, ticks change no register.
- R11: `reset_mask_o` equals day bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base pulse |
| load_i | input | 1 | Load all registers from `load_data_i` |
| load_data_i | input | 64 | Register image to load, register k in bits [8k+7:8k] |
| rd_data_o | output | 64 | Live register image |
| reset_mask_o | output | 1 | Stored reset-mask bit for the access controller |

## Verification
A wrong field value or a missed carry shows up on `rd_data_o` within a few cycles of the step that causes it. The carry sequencer finishes at most seven cycles after the step, so a wrong next-state decision leaves a stale or doubled field for the next read. A bad month-length or leap decision shows up only at the last date of a month. Because of this, each calendar boundary is loaded directly just before its rollover and then stepped once. A stale prescaler count is invisible until the next step, so it is exposed by reloading and then counting ticks that fall short of one step.

// File: rtl/bcdtk_pkg.sv
package bcdtk_pkg;
    localparam int TK_REGS  = 8;
    localparam int TK_IMG_W = TK_REGS * 8;

    localparam int RG_HUND = 0;
    localparam int RG_SEC  = 1;
    localparam int RG_MIN  = 2;
    localparam int RG_HOUR = 3;
    localparam int RG_DAY  = 4;
    localparam int RG_DATE = 5;
    localparam int RG_MON  = 6;
    localparam int RG_YEAR = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DATE, ST_MONTH, ST_YEAR
    } tk_state_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        return v + 8'd1;
    endfunction

    function automatic logic [7:0] bcd_wrap_inc(input logic [7:0] v,
                                                input logic [7:0] top,
                                                input logic [7:0] base);
        return (v >= top) ? base : bcd_inc(v);
    endfunction
endpackage

// File: rtl/bcdtk_prescale.sv
module bcdtk_prescale #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic en,
    output logic step
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign step = tick && en && (cnt_q == LAST);
endmodule

// File: rtl/bcdtk_month_len.sv
module bcdtk_month_len (
    input  logic [4:0] mon_bcd,
    input  logic [7:0] yr_bcd,
    output logic [5:0] last_bcd
);
    logic [6:0] yr_bin;
    logic       leap;

    always_comb begin
        yr_bin = 7'(yr_bcd[7:4]) * 7'd10 + 7'(yr_bcd[3:0]);
        leap   = (yr_bin[1:0] == 2'b00);
        case (mon_bcd)
            5'h02:                      last_bcd = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_bcd = 6'h30;
            default:                    last_bcd = 6'h31;
        endcase
    end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import bcdtk_pkg::*;
#(
    parameter int TICK_DIV = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                load_i,
    input  logic [TK_IMG_W-1:0] load_data_i,
    output logic [TK_IMG_W-1:0] rd_data_o,
    output logic                reset_mask_o
);
    tk_state_e state_q, state_d;

    logic [7:0] ld_byte [TK_REGS];
    for (genvar g = 0; g < TK_REGS; g++) begin : g_unpack
        assign ld_byte[g] = load_data_i[8*g +: 8];
    end

    logic [7:0] hund_q, yr_q;
    logic [6:0] sec_q, min_q;
    logic       hmode_q, hpm_q;
    logic [4:0] hlow_q, mon_q;
    logic [2:0] dow_q;
    logic       osc_stop_q, rmask_q, pend_q;
    logic [5:0] date_q, last_date;
    logic       step, go;

    logic [7:0] hund_nx, sec_nx, min_nx, date_nx, mon_nx, yr_nx, hr_tmp;
    logic [4:0] hr_low_d;
    logic       hr_pm_d, hr_wrap;

    bcdtk_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_i),
        .tick  (tick_i),
        .en    (!osc_stop_q),
        .step  (step)
    );

    bcdtk_month_len u_mlen (
        .mon_bcd  (mon_q),
        .yr_bcd   (yr_q),
        .last_bcd (last_date)
    );

    assign go = (state_q == ST_IDLE) && (step || pend_q);

    always_comb begin
        hund_nx = bcd_wrap_inc(hund_q, 8'h99, 8'h00);
        sec_nx  = bcd_wrap_inc({1'b0, sec_q}, 8'h59, 8'h00);
        min_nx  = bcd_wrap_inc({1'b0, min_q}, 8'h59, 8'h00);
        date_nx = bcd_wrap_inc({2'b0, date_q}, {2'b0, last_date}, 8'h01);
        mon_nx  = bcd_wrap_inc({3'b0, mon_q}, 8'h12, 8'h01);
        yr_nx   = bcd_wrap_inc(yr_q, 8'h99, 8'h00);
    end

    always_comb begin
        hr_low_d = hlow_q;
        hr_pm_d  = hpm_q;
        hr_wrap  = 1'b0;
        hr_tmp   = 8'h00;
        if (hmode_q) begin
            if (hlow_q == 5'h11) begin
                hr_low_d = 5'h12;
                hr_pm_d  = !hpm_q;
                hr_wrap  = hpm_q;
            end else if (hlow_q >= 5'h12) begin
                hr_low_d = 5'h01;
            end else begin
                hr_tmp   = bcd_inc({3'b0, hlow_q});
                hr_low_d = hr_tmp[4:0];
            end
        end else begin
            if ({hpm_q, hlow_q} >= 6'h23) begin
                {hr_pm_d, hr_low_d} = 6'h00;
                hr_wrap = 1'b1;
            end else begin
                hr_tmp = bcd_inc({2'b0, hpm_q, hlow_q});
                {hr_pm_d, hr_low_d} = hr_tmp[5:0];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (go && hund_q >= 8'h99) state_d = ST_SEC;
                ST_SEC:   state_d = (sec_q >= 7'h59) ? ST_MIN : ST_IDLE;
                ST_MIN:   state_d = (min_q >= 7'h59) ? ST_HOUR : ST_IDLE;
                ST_HOUR:  state_d = hr_wrap ? ST_DATE : ST_IDLE;
                ST_DATE:  state_d = (date_q >= last_date) ? ST_MONTH : ST_IDLE;
                ST_MONTH: state_d = (mon_q >= 5'h12) ? ST_YEAR : ST_IDLE;
                ST_YEAR:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hund_q     <= 8'h00;
            sec_q      <= 7'h00;
            min_q      <= 7'h00;
            hmode_q    <= 1'b0;
            hpm_q      <= 1'b0;
            hlow_q     <= 5'h00;
            dow_q      <= 3'd1;
            osc_stop_q <= 1'b0;
            rmask_q    <= 1'b0;
            date_q     <= 6'h01;
            mon_q      <= 5'h01;
            yr_q       <= 8'h00;
            pend_q     <= 1'b0;
        end else if (load_i) begin
            hund_q     <= ld_byte[RG_HUND];
            sec_q      <= ld_byte[RG_SEC][6:0];
            min_q      <= ld_byte[RG_MIN][6:0];
            hmode_q    <= ld_byte[RG_HOUR][7];
            hpm_q      <= ld_byte[RG_HOUR][5];
            hlow_q     <= ld_byte[RG_HOUR][4:0];
            osc_stop_q <= ld_byte[RG_DAY][5];
            rmask_q    <= ld_byte[RG_DAY][4];
            dow_q      <= ld_byte[RG_DAY][2:0];
            date_q     <= ld_byte[RG_DATE][5:0];
            mon_q      <= ld_byte[RG_MON][4:0];
            yr_q       <= ld_byte[RG_YEAR];
            pend_q     <= 1'b0;
        end else begin
            if (step && state_q != ST_IDLE) pend_q <= 1'b1;
            else if (state_q == ST_IDLE)    pend_q <= 1'b0;
            unique case (state_q)
                ST_IDLE:  if (go) hund_q <= hund_nx;
                ST_SEC:   sec_q <= sec_nx[6:0];
                ST_MIN:   min_q <= min_nx[6:0];
                ST_HOUR: begin
                    hpm_q  <= hr_pm_d;
                    hlow_q <= hr_low_d;
                end
                ST_DATE: begin
                    dow_q  <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
                    date_q <= date_nx[5:0];
                end
                ST_MONTH: mon_q <= mon_nx[4:0];
                ST_YEAR:  yr_q  <= yr_nx;
                default: ;
            endcase
        end
    end

    assign rd_data_o = {yr_q,
                        3'b000, mon_q,
                        2'b00, date_q,
                        2'b00, osc_stop_q, rmask_q, 1'b0, dow_q,
                        hmode_q, 1'b0, hpm_q, hlow_q,
                        1'b0, min_q,
                        1'b0, sec_q,
                        hund_q};
    assign reset_mask_o = rmask_q;
endmodule

// File: rtl/bcdtk_checker.sv
module bcdtk_checker
    import bcdtk_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                load_i,
    input logic [TK_IMG_W-1:0] load_data_i,
    input logic [TK_IMG_W-1:0] rd_data_o
);
    localparam logic [TK_IMG_W-1:0] LIVE_BITS = 64'hFF1F_3F37_BF7F_7FFF;

    function automatic logic [7:0] hund_after(input logic [7:0] v);
        return (v >= 8'h99) ? 8'h00 : bcd_inc(v);
    endfunction

    function automatic logic [7:0] hour24_after(input logic [5:0] v);
        return (v >= 6'h23) ? 8'h00 : bcd_inc({2'b00, v});
    endfunction

    // R2: a load shows its image, dead bits cleared, on the next cycle
    a_r2_load_image: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> rd_data_o == ($past(load_data_i) & LIVE_BITS));

    // R10: with the stop bit set nothing moves until a load
    a_r10_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[37] && !load_i) |=> $stable(rd_data_o));

    // R3: hundredths either hold or take exactly one BCD step
    a_r3_hund_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (rd_data_o[7:0] == $past(rd_data_o[7:0])) ||
                    (rd_data_o[7:0] == hund_after($past(rd_data_o[7:0]))));

    // R5: in 24-hour mode the hour field holds or takes one step, 23 wraps to 00
    a_r5_hour24_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !rd_data_o[31]) |=>
            (rd_data_o[29:24] == $past(rd_data_o[29:24])) ||
            ({2'b00, rd_data_o[29:24]} == hour24_after($past(rd_data_o[29:24]))));
endmodule

bind bcd_timekeeper bcdtk_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .rd_data_o   (rd_data_o)
);

// File: tb/bcd_timekeeper_tb.sv
module bcd_timekeeper_tb;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        load_i = 1'b0;
    logic [63:0] load_data_i = '0;
    logic [63:0] rd_data_o;
    logic        reset_mask_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    string       tag_q [$];
    logic [63:0] img_q [$];
    logic        msk_q [$];

    always #5 clk = !clk;

    bcd_timekeeper #(.TICK_DIV(DIV)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .load_i       (load_i),
        .load_data_i  (load_data_i),
        .rd_data_o    (rd_data_o),
        .reset_mask_o (reset_mask_o)
    );

    function automatic logic [63:0] img(input logic [7:0] h, s, m, hr, d, dt, mo, y);
        return {y, mo, dt, d, hr, m, s, h};
    endfunction

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(negedge clk);
            if (img_q.size() > 0) begin
                string       t;
                logic [63:0] e;
                logic        em;
                t  = tag_q.pop_front();
                e  = img_q.pop_front();
                em = msk_q.pop_front();
                vectors++;
                if (rd_data_o !== e || reset_mask_o !== em) begin
                    miscompares++;
                    $display("FAIL %s: got image %h mask %b, expected image %h mask %b",
                             t, rd_data_o, reset_mask_o, e, em);
                end
            end
        end
    end

    task automatic expect_img(input string t, input logic [63:0] e, input logic em);
        tag_q.push_back(t);
        img_q.push_back(e);
        msk_q.push_back(em);
        while (img_q.size() > 0) @(negedge clk);
    endtask

    task automatic load_img(input logic [63:0] v);
        @(negedge clk);
        load_i = 1'b1;
        load_data_i = v;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic step_hund();
        repeat (DIV) pulse_tick();
    endtask

    task automatic roll(input string t, input logic [63:0] start, input logic [63:0] e);
        load_img(start);
        step_hund();
        expect_img(t, e, start[36]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_img("R1 reset image", img(8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), 1'b0);

        load_img(img(8'h12,8'hD9,8'h87,8'h55,8'hCB,8'hD4,8'hE9,8'h77));
        expect_img("R2 load with dead bits set",
                   img(8'h12,8'h59,8'h07,8'h15,8'h03,8'h14,8'h09,8'h77), 1'b0);

        // R3 prescaler: partial count cleared by a reload
        load_img(img(8'h45,8'h30,8'h10,8'h08,8'h02,8'h05,8'h03,8'h22));
        pulse_tick();
        pulse_tick();
        load_img(img(8'h45,8'h30,8'h10,8'h08,8'h02,8'h05,8'h03,8'h22));
        pulse_tick();
        pulse_tick();
        expect_img("R3 partial count cleared by load",
                   img(8'h45,8'h30,8'h10,8'h08,8'h02,8'h05,8'h03,8'h22), 1'b0);
        pulse_tick();
        expect_img("R3 step after full count",
                   img(8'h46,8'h30,8'h10,8'h08,8'h02,8'h05,8'h03,8'h22), 1'b0);
        roll("R3 BCD digit carry 09->10",
             img(8'h09,8'h30,8'h10,8'h08,8'h02,8'h05,8'h03,8'h22),
             img(8'h10,8'h30,8'h10,8'h08,8'h02,8'h05,8'h03,8'h22));

        roll("R4 carry into hours",
             img(8'h99,8'h59,8'h59,8'h13,8'h03,8'h15,8'h06,8'h24),
             img(8'h00,8'h00,8'h00,8'h14,8'h03,8'h15,8'h06,8'h24));
        roll("R5 R7 R8 24h wrap, weekday 7->1, Apr 30",
             img(8'h99,8'h59,8'h59,8'h23,8'h07,8'h30,8'h04,8'h21),
             img(8'h00,8'h00,8'h00,8'h00,8'h01,8'h01,8'h05,8'h21));
        roll("R8 Feb 28 common year",
             img(8'h99,8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h23),
             img(8'h00,8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23));
        roll("R8 Feb 28 leap year",
             img(8'h99,8'h59,8'h59,8'h23,8'h02,8'h28,8'h02,8'h24),
             img(8'h00,8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h24));
        roll("R8 Feb 29 leap year",
             img(8'h99,8'h59,8'h59,8'h23,8'h03,8'h29,8'h02,8'h24),
             img(8'h00,8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h24));
        roll("R8 year 00 is leap",
             img(8'h99,8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h00),
             img(8'h00,8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h00));
        roll("R8 Jan 31",
             img(8'h99,8'h59,8'h59,8'h23,8'h04,8'h31,8'h01,8'h24),
             img(8'h00,8'h00,8'h00,8'h00,8'h05,8'h01,8'h02,8'h24));
        roll("R9 year and month wrap",
             img(8'h99,8'h59,8'h59,8'h23,8'h05,8'h31,8'h12,8'h99),
             img(8'h00,8'h00,8'h00,8'h00,8'h06,8'h01,8'h01,8'h00));

        roll("R6 11 AM to 12 PM",
             img(8'h99,8'h59,8'h59,8'h91,8'h02,8'h10,8'h03,8'h25),
             img(8'h00,8'h00,8'h00,8'hB2,8'h02,8'h10,8'h03,8'h25));
        roll("R6 11 PM to 12 AM advances date",
             img(8'h99,8'h59,8'h59,8'hB1,8'h02,8'h10,8'h03,8'h25),
             img(8'h00,8'h00,8'h00,8'h92,8'h03,8'h11,8'h03,8'h25));
        roll("R6 12 PM to 1 PM",
             img(8'h99,8'h59,8'h59,8'hB2,8'h02,8'h10,8'h03,8'h25),
             img(8'h00,8'h00,8'h00,8'hA1,8'h02,8'h10,8'h03,8'h25));
        roll("R6 9 AM to 10 AM",
             img(8'h99,8'h59,8'h59,8'h89,8'h02,8'h10,8'h03,8'h25),
             img(8'h00,8'h00,8'h00,8'h90,8'h02,8'h10,8'h03,8'h25));

        load_img(img(8'h50,8'h10,8'h20,8'h08,8'h21,8'h05,8'h03,8'h22));
        step_hund();
        step_hund();
        expect_img("R10 stopped clock ignores ticks",
                   img(8'h50,8'h10,8'h20,8'h08,8'h21,8'h05,8'h03,8'h22), 1'b0);

        load_img(img(8'h00,8'h00,8'h00,8'h00,8'h12,8'h01,8'h01,8'h00));
        expect_img("R11 mask bit set",
                   img(8'h00,8'h00,8'h00,8'h00,8'h12,8'h01,8'h01,8'h00), 1'b1);
        step_hund();
        expect_img("R11 mask kept while counting",
                   img(8'h01,8'h00,8'h00,8'h00,8'h12,8'h01,8'h01,8'h00), 1'b1);
        load_img(img(8'h00,8'h00,8'h00,8'h00,8'h02,8'h01,8'h01,8'h00));
        expect_img("R11 mask bit clear",
                   img(8'h00,8'h00,8'h00,8'h00,8'h02,8'h01,8'h01,8'h00), 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule